// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block runs the transmit side of a buffer-descriptor ring. A small local store holds one entry per descriptor. Each entry is a control/status word and a buffer address word. The host fills an entry and sets its ready bit, which hands the entry to the engine. The engine walks the ring in order. It stops on the first entry that is not ready and checks that entry again on every cycle.

When the engine finds a ready entry, it sends the frame's buffer address, length, pad request and CRC request to a transmit MAC port over a valid/ready handshake. It then waits for a one-cycle completion pulse that carries the frame status. The engine writes that status into the entry and clears the ready bit, which returns the entry to the host. If the entry allows it, the engine raises a frame-done or frame-error interrupt cause. The host reaches the descriptor store, a ring-length register, an interrupt cause register and an interrupt mask register through a simple word-wide port. Writes take effect at the clock edge. Reads are combinational.

Host map (byte offsets): ring length at 0x000, interrupt causes at 0x004, interrupt mask at 0x008. Descriptor `i` has its control word at 0x400 + 8·i and its address word at 0x404 + 8·i.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset the ring length reads DEPTH/2 (64 by default), the cause and mask registers read 0, `irq` is low and `tx_req_valid` is low.
- R2: A write to the ring-length register stores the written value, but never more than DEPTH (128 by default). Writing 200 reads back 128.
- R3: The engine holds on a descriptor whose ready bit (bit 15) is clear and issues no request for it. It checks the entry every cycle and issues the request once the host sets the bit.
- R4: A request carries the address word and the length from control bits [31:16]. `tx_req_crc` copies control bit 11. The request stays valid and unchanged until `tx_req_ready` is seen.
- R5: `tx_req_pad` is 1 only when control bit 12 is set and the length is below 64.
- R6: On completion the control word keeps bits [31:9] except that ready (bit 15) is cleared. Bits [8:0] take the status: bit 0 carrier lost, bit 1 deferred, bit 2 late collision, bit 3 retry limit, bits [7:4] retry count, bit 8 underrun.
- R7: After a descriptor the engine moves to the next index. It goes to index 0 instead when the descriptor's wrap bit (bit 13) was set, or when the index was ring length − 1.
- R8: A completion sets cause bit 1 (error) when any of carrier lost, late collision, retry limit or underrun is set, and cause bit 0 (done) otherwise. Nothing is set when the descriptor's interrupt-enable bit (bit 14) is clear.
- R9: Writing 1 to a cause bit clears it. Writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some cause bit is set and its mask bit (mask register bits [1:0]) is set.
- R11: A host write to the control word of the descriptor in flight is stored, but does not change the request already issued. The writeback then applies R6 to the newly stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| tx_req_valid | output | 1 | Frame request valid |
| tx_req_ready | input | 1 | MAC accepts the request |
| tx_req_addr | output | 32 | Frame buffer address |
| tx_req_len | output | 16 | Frame length in bytes |
| tx_req_pad | output | 1 | Pad the frame to minimum size |
| tx_req_crc | output | 1 | Append the frame check sequence |
| tx_done_valid | input | 1 | One-cycle completion pulse |
| tx_done_status | input | 9 | Completion status, same layout as control bits [8:0] |
| irq | output | 1 | Masked interrupt request |

## Verification
The ring is driven with these cases:
- A descriptor that is first left not-ready and then released. This separates stalling from skipping.
- Lengths of 40, 63, 64 and 100 with and without the pad bit. These pin down where the pad threshold lies.
- Status words with only deferral and retry count, with underrun, and with carrier loss. These separate the done cause from the error cause.
- A descriptor with interrupts disabled.
- One case ends a descriptor with its wrap bit set while the next entry is ready. This shows that the engine returns to index 0 instead of running on.
- Another case reaches the last index without a wrap bit.
- A control-word rewrite while the frame is in flight. This separates the value latched at fetch from the value that is finally written back.
- Holding the MAC ready low for several cycles shows that the request stays stable.

// File: rtl/tde_pkg.sv
package tde_pkg;

    localparam int          HOST_AW      = 12;
    localparam int          STAT_W       = 9;
    localparam int          LEN_W        = 16;
    localparam logic [11:0] BD_BASE      = 12'h400;
    localparam logic [11:0] REG_RING_LEN = 12'h000;
    localparam logic [11:0] REG_CAUSE    = 12'h004;
    localparam logic [11:0] REG_MASK     = 12'h008;
    localparam logic [15:0] MIN_FRAME    = 16'd64;

    typedef enum logic [1:0] {
        ENG_FETCH,
        ENG_ISSUE,
        ENG_AWAIT
    } eng_state_t;

    typedef struct packed {
        logic [15:0] len;
        logic        ready;
        logic        irq_en;
        logic        wrap;
        logic        pad;
        logic        crc;
    } ctl_t;

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] len;
        logic        pad;
        logic        crc;
    } tx_req_t;

    function automatic ctl_t decode_ctl(input logic [31:0] w);
        ctl_t c;
        c.len    = w[31:16];
        c.ready  = w[15];
        c.irq_en = w[14];
        c.wrap   = w[13];
        c.pad    = w[12];
        c.crc    = w[11];
        return c;
    endfunction

    // Carrier lost, late collision, retry limit, underrun count as errors.
    function automatic logic status_is_error(input logic [STAT_W-1:0] s);
        return s[0] | s[2] | s[3] | s[8];
    endfunction

    // Clear ownership and replace the status field; keep the rest.
    function automatic logic [31:0] merge_status(input logic [31:0] w,
                                                 input logic [STAT_W-1:0] s);
        return {w[31:16], 1'b0, w[14:STAT_W], s};
    endfunction

endpackage

// File: rtl/tde_desc_mem.sv
module tde_desc_mem
    import tde_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    // host port
    input  logic              h_we,
    input  logic [IDXW-1:0]   h_idx,
    input  logic              h_sel,      // 0: control word, 1: address word
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    // engine fetch port
    input  logic [IDXW-1:0]   e_idx,
    output logic [31:0]       e_ctl,
    output logic [31:0]       e_addr,
    // engine writeback port
    input  logic              wb_en,
    input  logic [IDXW-1:0]   wb_idx,
    input  logic [STAT_W-1:0] wb_status
);

    logic [DEPTH-1:0][31:0] ctl_v;
    logic [DEPTH-1:0][31:0] adr_v;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [31:0] ctl_r;
        logic [31:0] adr_r;
        logic        wb_hit;
        logic        h_hit;

        assign wb_hit = wb_en && (wb_idx == IDXW'(e));
        assign h_hit  = h_we && (h_idx == IDXW'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_r <= '0;
                adr_r <= '0;
            end else begin
                // engine writeback wins over a same-cycle host control write
                if (wb_hit)
                    ctl_r <= merge_status(ctl_r, wb_status);
                else if (h_hit && !h_sel)
                    ctl_r <= h_wdata;
                if (h_hit && h_sel)
                    adr_r <= h_wdata;
            end
        end

        assign ctl_v[e] = ctl_r;
        assign adr_v[e] = adr_r;
    end

    assign e_ctl   = ctl_v[e_idx];
    assign e_addr  = adr_v[e_idx];
    assign h_rdata = h_sel ? adr_v[h_idx] : ctl_v[h_idx];

endmodule

// File: rtl/tde_ring_fsm.sv
module tde_ring_fsm
    import tde_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int IDXW  = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  ring_len,
    output logic [IDXW-1:0]   cur_idx,
    input  logic [31:0]       cur_ctl,
    input  logic [31:0]       cur_addr,
    output tx_req_t           req,
    output logic              req_valid,
    input  logic              req_ready,
    input  logic              done_valid,
    input  logic [STAT_W-1:0] done_status,
    output logic              wb_en,
    output logic [IDXW-1:0]   wb_idx,
    output logic [STAT_W-1:0] wb_status,
    output logic              ev_ok,
    output logic              ev_err
);

    eng_state_t      state_q;
    logic [IDXW-1:0] idx_q;
    tx_req_t         req_q;
    logic            wrap_q;
    logic            ie_q;

    ctl_t            ctl;
    logic [CNT_W-1:0] idx_ext;
    logic            at_last;
    logic            out_of_range;
    logic            err;

    assign ctl          = decode_ctl(cur_ctl);
    assign idx_ext      = CNT_W'(idx_q);
    assign at_last      = (idx_ext == ring_len - 1'b1);
    assign out_of_range = (idx_ext >= ring_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_FETCH;
            idx_q   <= '0;
            req_q   <= '0;
            wrap_q  <= 1'b0;
            ie_q    <= 1'b0;
        end else begin
            case (state_q)
                ENG_FETCH: begin
                    if (ring_len != '0) begin
                        if (out_of_range) begin
                            idx_q <= '0;
                        end else if (ctl.ready) begin
                            req_q.addr <= cur_addr;
                            req_q.len  <= ctl.len;
                            req_q.pad  <= ctl.pad && (ctl.len < MIN_FRAME);
                            req_q.crc  <= ctl.crc;
                            wrap_q     <= ctl.wrap;
                            ie_q       <= ctl.irq_en;
                            state_q    <= ENG_ISSUE;
                        end
                    end
                end
                ENG_ISSUE: begin
                    if (req_ready)
                        state_q <= ENG_AWAIT;
                end
                ENG_AWAIT: begin
                    if (done_valid) begin
                        idx_q   <= (wrap_q || at_last) ? '0 : idx_q + 1'b1;
                        state_q <= ENG_FETCH;
                    end
                end
                default: state_q <= ENG_FETCH;
            endcase
        end
    end

    assign cur_idx   = idx_q;
    assign req       = req_q;
    assign req_valid = (state_q == ENG_ISSUE);
    assign wb_en     = (state_q == ENG_AWAIT) && done_valid;
    assign wb_idx    = idx_q;
    assign wb_status = done_status;
    assign err       = status_is_error(done_status);
    assign ev_ok     = wb_en && ie_q && !err;
    assign ev_err    = wb_en && ie_q && err;

endmodule

// File: rtl/tde_int_regs.sv
module tde_int_regs
    import tde_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             len_we,
    input  logic             cause_we,
    input  logic             mask_we,
    input  logic [31:0]      wdata,
    input  logic             ev_ok,
    input  logic             ev_err,
    output logic [CNT_W-1:0] ring_len,
    output logic [1:0]       cause,
    output logic [1:0]       mask,
    output logic             irq
);

    localparam logic [CNT_W-1:0] LEN_MAX   = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LEN_RESET = CNT_W'(DEPTH / 2);

    logic [1:0] clr;
    logic [1:0] set;

    assign clr = cause_we ? wdata[1:0] : 2'b00;
    assign set = {ev_err, ev_ok};

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_len <= LEN_RESET;
            cause    <= '0;
            mask     <= '0;
        end else begin
            if (len_we)
                ring_len <= (wdata > 32'(DEPTH)) ? LEN_MAX : wdata[CNT_W-1:0];
            cause <= (cause & ~clr) | set;
            if (mask_we)
                mask <= wdata[1:0];
        end
    end

    assign irq = |(cause & mask);

endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine
    import tde_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [11:0] host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        tx_req_valid,
    input  logic        tx_req_ready,
    output logic [31:0] tx_req_addr,
    output logic [15:0] tx_req_len,
    output logic        tx_req_pad,
    output logic        tx_req_crc,
    input  logic        tx_done_valid,
    input  logic [8:0]  tx_done_status,
    output logic        irq
);

    localparam int          IDXW   = $clog2(DEPTH);
    localparam int          CNT_W  = $clog2(DEPTH + 1);
    localparam logic [12:0] BD_END = 13'(BD_BASE) + 13'(DEPTH * 8);

    logic              in_bd;
    logic [11:0]       bd_off;
    logic [IDXW-1:0]   h_idx;
    logic              h_sel;
    logic [31:0]       bd_rdata;

    logic [IDXW-1:0]   e_idx;
    logic [31:0]       e_ctl;
    logic [31:0]       e_addr;
    logic              wb_en;
    logic [IDXW-1:0]   wb_idx;
    logic [STAT_W-1:0] wb_status;
    logic              ev_ok;
    logic              ev_err;
    tx_req_t           req;

    logic [CNT_W-1:0]  ring_len;
    logic [1:0]        cause;
    logic [1:0]        mask;

    assign in_bd  = (host_addr >= BD_BASE) && (13'(host_addr) < BD_END);
    assign bd_off = host_addr - BD_BASE;
    assign h_idx  = bd_off[IDXW+2:3];
    assign h_sel  = bd_off[2];

    tde_desc_mem #(.DEPTH(DEPTH), .IDXW(IDXW)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .h_we      (host_wr && in_bd),
        .h_idx     (h_idx),
        .h_sel     (h_sel),
        .h_wdata   (host_wdata),
        .h_rdata   (bd_rdata),
        .e_idx     (e_idx),
        .e_ctl     (e_ctl),
        .e_addr    (e_addr),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_status (wb_status)
    );

    tde_ring_fsm #(.DEPTH(DEPTH), .IDXW(IDXW), .CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ring_len    (ring_len),
        .cur_idx     (e_idx),
        .cur_ctl     (e_ctl),
        .cur_addr    (e_addr),
        .req         (req),
        .req_valid   (tx_req_valid),
        .req_ready   (tx_req_ready),
        .done_valid  (tx_done_valid),
        .done_status (tx_done_status),
        .wb_en       (wb_en),
        .wb_idx      (wb_idx),
        .wb_status   (wb_status),
        .ev_ok       (ev_ok),
        .ev_err      (ev_err)
    );

    tde_int_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .len_we   (host_wr && (host_addr == REG_RING_LEN)),
        .cause_we (host_wr && (host_addr == REG_CAUSE)),
        .mask_we  (host_wr && (host_addr == REG_MASK)),
        .wdata    (host_wdata),
        .ev_ok    (ev_ok),
        .ev_err   (ev_err),
        .ring_len (ring_len),
        .cause    (cause),
        .mask     (mask),
        .irq      (irq)
    );

    assign tx_req_addr = req.addr;
    assign tx_req_len  = req.len;
    assign tx_req_pad  = req.pad;
    assign tx_req_crc  = req.crc;

    always_comb begin
        host_rdata = '0;
        if (in_bd)
            host_rdata = bd_rdata;
        else if (host_addr == REG_RING_LEN)
            host_rdata = 32'(ring_len);
        else if (host_addr == REG_CAUSE)
            host_rdata = {30'b0, cause};
        else if (host_addr == REG_MASK)
            host_rdata = {30'b0, mask};
    end

endmodule

// File: rtl/tde_chk.sv
module tde_chk #(
    parameter int DEPTH = 128,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_req_valid,
    input logic             tx_req_ready,
    input logic [31:0]      tx_req_addr,
    input logic [15:0]      tx_req_len,
    input logic             tx_req_pad,
    input logic [CNT_W-1:0] ring_len,
    input logic [1:0]       cause,
    input logic [1:0]       mask,
    input logic             wb_en,
    input logic             irq
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!tx_req_valid && cause == 2'b00 && mask == 2'b00));

    // R2
    len_sat_chk: assert property (@(posedge clk) disable iff (rst)
        ring_len <= CNT_W'(DEPTH));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_req_valid && !tx_req_ready) |=>
            (tx_req_valid && $stable(tx_req_addr) && $stable(tx_req_len)));

    // R5
    pad_short_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_req_valid && tx_req_pad) |-> (tx_req_len < 16'd64));

    // R8
    cause_src_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cause[0]) || $rose(cause[1])) |-> $past(wb_en));

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (mask == 2'b00) |-> !irq);

endmodule

bind tx_desc_engine tde_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_req_valid (tx_req_valid),
    .tx_req_ready (tx_req_ready),
    .tx_req_addr  (tx_req_addr),
    .tx_req_len   (tx_req_len),
    .tx_req_pad   (tx_req_pad),
    .ring_len     (ring_len),
    .cause        (cause),
    .mask         (mask),
    .wb_en        (wb_en),
    .irq          (irq)
);

// File: tb/tx_desc_engine_tb_top.sv
module tx_desc_engine_tb_top;

    localparam logic [31:0] RDY  = 32'h8000;
    localparam logic [31:0] IE   = 32'h4000;
    localparam logic [31:0] WRP  = 32'h2000;
    localparam logic [31:0] PADB = 32'h1000;
    localparam logic [31:0] CRCB = 32'h0800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        tx_req_valid;
    logic        tx_req_ready = 1'b0;
    logic [31:0] tx_req_addr;
    logic [15:0] tx_req_len;
    logic        tx_req_pad;
    logic        tx_req_crc;
    logic        tx_done_valid = 1'b0;
    logic [8:0]  tx_done_status = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int hs_cnt = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    logic [49:0] exp_q[$];   // {addr, len, pad, crc}
    logic [8:0]  st_q[$];
    int          dly_q[$];

    always #10 clk = ~clk;

    tx_desc_engine dut_i (
        .clk            (clk),
        .rst            (rst),
        .host_wr        (host_wr),
        .host_addr      (host_addr),
        .host_wdata     (host_wdata),
        .host_rdata     (host_rdata),
        .tx_req_valid   (tx_req_valid),
        .tx_req_ready   (tx_req_ready),
        .tx_req_addr    (tx_req_addr),
        .tx_req_len     (tx_req_len),
        .tx_req_pad     (tx_req_pad),
        .tx_req_crc     (tx_req_crc),
        .tx_done_valid  (tx_done_valid),
        .tx_done_status (tx_done_status),
        .irq            (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    function automatic logic [11:0] ctl_at(input int i);
        return 12'(12'h400 + 8 * i);
    endfunction

    // driver: push expected request and the status to answer with
    task automatic expect_req(input logic [31:0] a, input logic [15:0] l,
                              input logic p, input logic c,
                              input logic [8:0] st, input int dly);
        exp_q.push_back({a, l, p, c});
        st_q.push_back(st);
        dly_q.push_back(dly);
    endtask

    task automatic post(input int i, input logic [31:0] a, input logic [31:0] ctl);
        wr(ctl_at(i) + 12'd4, a);
        wr(ctl_at(i), ctl);
    endtask

    task automatic wait_done(input int n);
        while (done_cnt < n) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: accepts requests after a stall, compares, answers
    initial begin
        forever begin
            @(negedge clk);
            if (tx_req_valid) begin
                logic [49:0] first;
                logic [49:0] item;
                logic [8:0]  st;
                int          dly;
                first = {tx_req_addr, tx_req_len, tx_req_pad, tx_req_crc};
                repeat (3) @(negedge clk);
                check("R4 hold", {31'b0, tx_req_valid}, 32'd1);
                check("R4 stable", 32'({tx_req_addr, tx_req_len, tx_req_pad, tx_req_crc} == first), 32'd1);
                if (exp_q.size() == 0) begin
                    errors++; checks++;
                    $display("FAIL R3 unexpected request: actual=%h expected=none", tx_req_addr);
                    item = first; st = '0; dly = 1;
                end else begin
                    item = exp_q.pop_front();
                    st   = st_q.pop_front();
                    dly  = dly_q.pop_front();
                end
                check("R4 addr", first[49:18], item[49:18]);
                check("R4 len", 32'(first[17:2]), 32'(item[17:2]));
                check("R5 pad", 32'(first[1]), 32'(item[1]));
                check("R4 crc", 32'(first[0]), 32'(item[0]));
                tx_req_ready = 1'b1;
                @(negedge clk);
                tx_req_ready = 1'b0;
                hs_cnt++;
                repeat (dly) @(negedge clk);
                tx_done_valid = 1'b1; tx_done_status = st;
                @(negedge clk);
                tx_done_valid = 1'b0; tx_done_status = '0;
                done_cnt++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12'h000, v); check("R1 ring length", v, 32'd64);
        rd(12'h004, v); check("R1 cause", v, 32'd0);
        rd(12'h008, v); check("R1 mask", v, 32'd0);
        check("R1 irq/valid", {30'b0, irq, tx_req_valid}, 32'd0);

        // R2 saturation
        wr(12'h000, 32'd200); rd(12'h000, v); check("R2 saturate", v, 32'd128);
        wr(12'h000, 32'd4);   rd(12'h000, v); check("R2 plain", v, 32'd4);
        wr(12'h008, 32'd3);

        // R3 stall on a not-ready entry, then release
        post(0, 32'h1000, (32'd40 << 16) | IE | PADB | CRCB);
        repeat (8) @(negedge clk);
        check("R3 stall valid", {31'b0, tx_req_valid}, 32'd0);
        check("R3 stall count", 32'(hs_cnt), 32'd0);
        expect_req(32'h1000, 16'd40, 1'b1, 1'b1, 9'h052, 2);
        wr(ctl_at(0), (32'd40 << 16) | IE | PADB | CRCB | RDY);
        wait_done(1);
        rd(ctl_at(0), v);
        check("R6 writeback", v, (32'd40 << 16) | IE | PADB | CRCB | 32'h052);
        rd(12'h004, v); check("R8 done cause", v, 32'd1);
        check("R10 irq on", {31'b0, irq}, 32'd1);
        wr(12'h004, 32'd1);
        rd(12'h004, v); check("R9 clear", v, 32'd0);
        check("R10 irq off", {31'b0, irq}, 32'd0);

        // underrun -> error cause, long frame not padded
        expect_req(32'h2000, 16'd100, 1'b0, 1'b0, 9'h100, 2);
        post(1, 32'h2000, (32'd100 << 16) | IE | PADB | RDY);
        wait_done(2);
        rd(12'h004, v); check("R8 error cause", v, 32'd2);
        wr(12'h004, 32'd0);
        rd(12'h004, v); check("R9 write zero keeps", v, 32'd2);
        wr(12'h004, 32'd2);

        // interrupts disabled, length 63 padded
        expect_req(32'h3000, 16'd63, 1'b1, 1'b0, 9'h000, 2);
        post(2, 32'h3000, (32'd63 << 16) | PADB | RDY);
        wait_done(3);
        rd(12'h004, v); check("R8 ie clear", v, 32'd0);
        rd(ctl_at(2), v); check("R6 ready cleared", v, (32'd63 << 16) | PADB);

        // length 64 not padded, last index wraps, carrier lost is error
        expect_req(32'h4000, 16'd64, 1'b0, 1'b1, 9'h001, 2);
        post(3, 32'h4000, (32'd64 << 16) | IE | PADB | CRCB | RDY);
        wait_done(4);
        rd(12'h004, v); check("R8 carrier error", v, 32'd2);
        wr(12'h004, 32'd3);

        // R7 wrap bit: after entry 0 with wrap, entry 1 must not be served
        wr(ctl_at(1), (32'd30 << 16) | IE | RDY);
        expect_req(32'h1000, 16'd20, 1'b1, 1'b0, 9'h000, 2);
        wr(ctl_at(0), (32'd20 << 16) | IE | PADB | WRP | RDY);
        wait_done(5);
        repeat (10) @(negedge clk);
        check("R7 wrap no advance", 32'(hs_cnt), 32'd5);
        rd(ctl_at(1), v); check("R7 entry1 still ready", v, (32'd30 << 16) | IE | RDY);
        expect_req(32'h1000, 16'd50, 1'b0, 1'b0, 9'h000, 2);
        expect_req(32'h2000, 16'd30, 1'b0, 1'b0, 9'h000, 2);
        wr(ctl_at(0), (32'd50 << 16) | IE | RDY);
        wait_done(7);
        rd(12'h004, v); check("R7 order done", v, 32'd1);
        wr(12'h004, 32'd1);

        // R11 rewrite in flight, with mask closed (R10)
        wr(12'h008, 32'd0);
        expect_req(32'h5000, 16'd200, 1'b0, 1'b0, 9'h000, 20);
        post(2, 32'h5000, (32'd200 << 16) | IE | RDY);
        while (hs_cnt < 8) @(negedge clk);
        wr(ctl_at(2), (32'd77 << 16) | IE | RDY);
        wait_done(8);
        rd(ctl_at(2), v); check("R11 stored rewrite", v, (32'd77 << 16) | IE);
        rd(12'h004, v); check("R10 cause masked", v, 32'd1);
        check("R10 irq masked", {31'b0, irq}, 32'd0);
        wr(12'h008, 32'd1);
        check("R10 irq unmasked", {31'b0, irq}, 32'd1);

        check("R3 no leftover", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule